// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

This block runs once, straight after reset is released. It acts as a two-wire bus master and fetches a fixed configuration image from an external serial EEPROM in one sequential read. It writes each byte into a local configuration store. Host reads of that store are held off until the load has finished, so software never sees a partly loaded map.

The transfer begins at the slow bus rate. One bit in the image can ask for the fast rate, and the switch then applies to every byte that follows. The last byte of the image holds a CRC-8 of all the bytes before it. The loaded contents are released to the host only if that check passes. Three conditions end the load with an error and leave the store reading as zero: a refused byte on the bus, a CRC mismatch, or a clock held low for too long.

Top module: `bootld_loader`

## Requirements
- R1: After reset is released, the block reports busy and sends this sequence on the bus: START, 0xA0 (7-bit device address 1010000 with the write bit), 0x00, 0x00, a repeated START, then 0xA1 (the same address with the read bit).
- R2: The block reads exactly IMG_LAST+1 bytes in one continuous burst, starting at byte address 0. It acknowledges every byte except the final one. It does not acknowledge the final byte, and it then issues STOP.
- R3: Each bit lasts 4*SLOW_Q+2 clock cycles at first (four quarter phases, plus two cycles of input synchronisation on the clock release). If bit 7 of the byte at address SPEED_IDX (1) is 1, every byte from address SPEED_IDX+1 onward uses 4*FAST_Q+2 cycles per bit. If that bit is 0, the slow timing stays in force.
- R4: A CRC-8 with polynomial 0x07 and initial value 0x00 is run over bytes 0 to IMG_LAST-1, fed most significant bit first, and compared with byte IMG_LAST. A match ends the load with done=1 and err=0. A mismatch ends it with done=1 and err=1. Once done is set, it stays set until the next reset.
- R5: If the EEPROM does not acknowledge any of the four bytes the master sends, the master issues STOP, reads no data bytes, and ends with done=1 and err=1.
- R6: The block tolerates the EEPROM holding SCL low for up to TIMEOUT cycles within a bit; such a hold only delays the load. A longer hold ends the load with done=1 and err=1.
- R7: host_ack is 0 whenever busy is 1. After the load has finished, host_ack goes to 1 in the cycle after a host_rd request.
- R8: After a good load, a host read of an address below IMG_LAST returns the image byte at that address, and a read of any higher address returns 0x00. After a failed load, every read returns 0x00.
- R9: scl_oe and sda_oe are pull-low enables: 1 pulls the line low and 0 releases it. Both are 0 during reset and whenever done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Level sensed on the bus clock line |
| sda_i | input | 1 | Level sensed on the bus data line |
| scl_oe | output | 1 | Pull the clock line low when 1 |
| sda_oe | output | 1 | Pull the data line low when 1 |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished, successfully or not |
| err | output | 1 | Load finished with an error |
| host_rd | input | 1 | Host read request |
| host_addr | input | $clog2(IMG_LAST+1) | Host read address |
| host_ack | output | 1 | Host read accepted, data valid |
| host_rdata | output | 8 | Host read data |

## Verification
The bench drives a 16-byte image through a behavioural EEPROM model and sweeps every host address after each load. It measures the bit period of byte 1 and byte 2 separately. A design that switched speed one byte early or one byte late would fail one of those two periods. Separate runs refuse the device address byte, refuse the low word-address byte, and corrupt the stored CRC. A loader that ignored a refusal would go on to read data bytes. One that skipped the comparison would release the map to the host. One run holds the clock low briefly and another holds it too long. A counter that never restarted would time out on the short hold, and one that never expired would hang on the long hold.

// File: rtl/bootld_pkg.sv
package bootld_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bus_op_e;

    // CRC-8, polynomial x^8+x^2+x+1, one byte folded in MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
        logic [7:0] c;
        c = crc ^ data;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/bootld_bitio.sv
module bootld_bitio
    import bootld_pkg::*;
#(
    parameter int SLOW_Q  = 312,
    parameter int FAST_Q  = 78,
    parameter int TIMEOUT = 125000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  bus_op_e    cmd_op,
    input  logic [7:0] cmd_tx,
    input  logic       cmd_ack,
    input  logic       fast,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       cmd_done,
    output logic [7:0] rx_byte,
    output logic       ack_seen,
    output logic       tout,
    output logic       scl_oe,
    output logic       sda_oe
);

    localparam int MAXQ = (SLOW_Q > FAST_Q) ? SLOW_Q : FAST_Q;
    localparam int QW   = $clog2(MAXQ + 1);
    localparam int TW   = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic          busy;
        bus_op_e       op;
        logic [1:0]    ph;
        logic [QW-1:0] qcnt;
        logic [3:0]    bitn;
        logic [7:0]    sh;
        logic          ackb;
        logic [TW-1:0] tcnt;
        logic          scl;
        logic          sda;
        logic          done;
        logic          ack;
        logic          tout;
    } phy_t;

    phy_t q, d;
    logic [QW-1:0] qlast;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.tout = 1'b0;
        qlast  = fast ? QW'(FAST_Q - 1) : QW'(SLOW_Q - 1);
        if (!q.busy) begin
            if (cmd_valid) begin
                d.busy = 1'b1;
                d.op   = cmd_op;
                d.sh   = cmd_tx;
                d.ackb = cmd_ack;
                d.ph   = 2'd0;
                d.qcnt = '0;
                d.bitn = 4'd0;
                d.tcnt = '0;
                d.scl  = 1'b1;
            end
        end else if (q.ph == 2'd2 && !scl_in) begin
            // clock released but still low: slave is stretching
            if (q.tcnt == TW'(TIMEOUT)) begin
                d.busy = 1'b0;
                d.scl  = 1'b0;
                d.sda  = 1'b0;
                d.done = 1'b1;
                d.tout = 1'b1;
            end else begin
                d.tcnt = q.tcnt + 1'b1;
            end
        end else if (q.qcnt != qlast) begin
            d.qcnt = q.qcnt + 1'b1;
        end else begin
            d.qcnt = '0;
            d.ph   = q.ph + 2'd1;
            case (q.ph)
                2'd0: begin
                    case (q.op)
                        OP_START: d.sda = 1'b0;
                        OP_STOP:  d.sda = 1'b1;
                        OP_WRITE: d.sda = (q.bitn == 4'd8) ? 1'b0 : ~q.sh[7];
                        default:  d.sda = (q.bitn == 4'd8) ? q.ackb : 1'b0;
                    endcase
                end
                2'd1: d.scl = 1'b0;
                2'd2: begin
                    case (q.op)
                        OP_START: d.sda = 1'b1;
                        OP_STOP:  d.sda = 1'b0;
                        OP_WRITE: begin
                            if (q.bitn == 4'd8) d.ack = ~sda_in;
                            else                d.sh  = {q.sh[6:0], 1'b0};
                        end
                        default: begin
                            if (q.bitn != 4'd8) d.sh = {q.sh[6:0], sda_in};
                        end
                    endcase
                end
                default: begin
                    if (q.op == OP_START || q.op == OP_STOP || q.bitn == 4'd8) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.bitn = q.bitn + 4'd1;
                        d.scl  = 1'b1;
                        d.tcnt = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_done = q.done;
    assign rx_byte  = q.sh;
    assign ack_seen = q.ack;
    assign tout     = q.tout;
    assign scl_oe   = q.scl;
    assign sda_oe   = q.sda;

endmodule

// File: rtl/bootld_stage.sv
module bootld_stage #(
    parameter int DEPTH = 926,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    input  logic          open,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ack,
    output logic [7:0]    rd_data
);

    typedef struct packed {
        logic       ack;
        logic [7:0] data;
    } port_t;

    logic [7:0] mem [DEPTH];
    port_t q, d;

    always_ff @(posedge clk) begin
        if (wr_en && wr_addr < AW'(DEPTH)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        d     = q;
        d.ack = rd_req && open;
        if (rd_req && open) begin
            d.data = (commit && rd_addr < AW'(DEPTH)) ? mem[rd_addr] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_ack  = q.ack;
    assign rd_data = q.data;

endmodule

// File: rtl/bootld_loader.sv
module bootld_loader
    import bootld_pkg::*;
#(
    parameter int         IMG_LAST  = 926,
    parameter logic [6:0] DEV_ADDR  = 7'b1010000,
    parameter int         SPEED_IDX = 1,
    parameter int         SLOW_Q    = 312,
    parameter int         FAST_Q    = 78,
    parameter int         TIMEOUT   = 125000,
    localparam int        AW        = $clog2(IMG_LAST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          busy,
    output logic          done,
    output logic          err,
    input  logic          host_rd,
    input  logic [AW-1:0] host_addr,
    output logic          host_ack,
    output logic [7:0]    host_rdata
);

    typedef enum logic [3:0] {
        L_START, L_DEVW, L_AHI, L_ALO, L_RST, L_DEVR, L_READ, L_STOP, L_OK, L_FAIL
    } lst_e;

    typedef struct packed {
        lst_e          st;
        logic          issued;
        logic [AW-1:0] idx;
        logic [7:0]    crc;
        logic          fast;
        logic          crc_ok;
        logic          nacked;
        logic [1:0]    scl_s;
        logic [1:0]    sda_s;
    } seq_t;

    seq_t q, d;

    logic          p_go, p_ack_send, p_done, p_ackin, p_tout;
    bus_op_e       p_op;
    logic [7:0]    p_tx, p_rx;
    logic          w_en;
    logic          fin;

    always_comb begin
        d          = q;
        d.scl_s    = {q.scl_s[0], scl_i};
        d.sda_s    = {q.sda_s[0], sda_i};
        p_go       = 1'b0;
        p_op       = OP_START;
        p_tx       = 8'h00;
        p_ack_send = 1'b0;
        w_en       = 1'b0;
        case (q.st)
            L_DEVW:  begin p_op = OP_WRITE; p_tx = {DEV_ADDR, 1'b0}; end
            L_AHI:   p_op = OP_WRITE;
            L_ALO:   p_op = OP_WRITE;
            L_DEVR:  begin p_op = OP_WRITE; p_tx = {DEV_ADDR, 1'b1}; end
            L_READ:  begin p_op = OP_READ; p_ack_send = (q.idx != AW'(IMG_LAST)); end
            L_STOP:  p_op = OP_STOP;
            default: p_op = OP_START;
        endcase
        if (q.st != L_OK && q.st != L_FAIL) begin
            if (!q.issued) begin
                p_go     = 1'b1;
                d.issued = 1'b1;
            end else if (p_done) begin
                d.issued = 1'b0;
                if (p_tout) begin
                    d.st = L_FAIL;
                end else begin
                    case (q.st)
                        L_START: d.st = L_DEVW;
                        L_RST:   d.st = L_DEVR;
                        L_DEVW, L_AHI, L_ALO, L_DEVR: begin
                            if (!p_ackin) begin
                                d.nacked = 1'b1;
                                d.st     = L_STOP;
                            end else begin
                                case (q.st)
                                    L_DEVW:  d.st = L_AHI;
                                    L_AHI:   d.st = L_ALO;
                                    L_ALO:   d.st = L_RST;
                                    default: d.st = L_READ;
                                endcase
                            end
                        end
                        L_READ: begin
                            if (q.idx != AW'(IMG_LAST)) begin
                                w_en  = 1'b1;
                                d.crc = crc8_step(q.crc, p_rx);
                                if (q.idx == AW'(SPEED_IDX) && p_rx[7]) d.fast = 1'b1;
                                d.idx = q.idx + 1'b1;
                            end else begin
                                d.crc_ok = (p_rx == q.crc);
                                d.st     = L_STOP;
                            end
                        end
                        default: d.st = (q.nacked || !q.crc_ok) ? L_FAIL : L_OK;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= L_START;
            q.scl_s <= 2'b11;
            q.sda_s <= 2'b11;
        end else begin
            q <= d;
        end
    end

    bootld_bitio #(
        .SLOW_Q  (SLOW_Q),
        .FAST_Q  (FAST_Q),
        .TIMEOUT (TIMEOUT)
    ) u_bitio (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (p_go),
        .cmd_op    (p_op),
        .cmd_tx    (p_tx),
        .cmd_ack   (p_ack_send),
        .fast      (q.fast),
        .scl_in    (q.scl_s[1]),
        .sda_in    (q.sda_s[1]),
        .cmd_done  (p_done),
        .rx_byte   (p_rx),
        .ack_seen  (p_ackin),
        .tout      (p_tout),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    assign fin = (q.st == L_OK) || (q.st == L_FAIL);

    bootld_stage #(
        .DEPTH (IMG_LAST),
        .AW    (AW)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (w_en),
        .wr_addr (q.idx),
        .wr_data (p_rx),
        .commit  (q.st == L_OK),
        .open    (fin),
        .rd_req  (host_rd),
        .rd_addr (host_addr),
        .rd_ack  (host_ack),
        .rd_data (host_rdata)
    );

    assign busy = !fin;
    assign done = fin;
    assign err  = (q.st == L_FAIL);

endmodule

// File: rtl/bootld_chk.sv
module bootld_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       host_ack,
    input logic [7:0] host_rdata
);

    // R9
    lines_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scl_oe && !sda_oe));

    // R7
    host_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_ack);

    // R4
    err_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R4
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R8
    no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err || busy) |-> (host_rdata == 8'h00));

endmodule

bind bootld_loader bootld_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .host_ack   (host_ack),
    .host_rdata (host_rdata)
);

// File: tb/bootld_loader_tb.sv
module bootld_loader_tb;

    localparam int LAST = 15;
    localparam int SQ   = 4;
    localparam int FQ   = 2;
    localparam int TO   = 64;
    localparam int AW   = $clog2(LAST + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic scl_oe, sda_oe, busy, done, err, host_ack;
    logic [7:0] host_rdata;
    logic tb_hold = 1'b0;
    logic sl_low = 1'b0;
    logic scl, sda;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // scenario knobs, written only by the stimulus process
    logic [7:0] img [16];
    int nack_at = -1;
    int hold_len = 0;
    int hold_byte = -1;

    // slave model state, written only by the slave process
    int n_start, n_stop, n_reads, n_mack, n_mnack, nack_addr, wcnt;
    logic [7:0] rxlog [8];
    int per [16];

    assign scl = !(scl_oe || tb_hold);
    assign sda = !(sda_oe || sl_low);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bootld_loader #(
        .IMG_LAST (LAST),
        .SLOW_Q   (SQ),
        .FAST_Q   (FQ),
        .TIMEOUT  (TO)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_ack   (host_ack),
        .host_rdata (host_rdata)
    );

    // behavioural EEPROM: 0 idle, 1 receiving, 2 sending
    int mode, sbit, tbit, sl_addr, ahi, last_rise, hold_cnt;
    logic [7:0] ssh;
    logic acking, snack, p_scl, p_sda;

    always @(negedge clk) begin
        if (!rst_n) begin
            mode = 0; sbit = 0; tbit = 0; sl_addr = 0; ahi = 0; last_rise = 0;
            acking = 0; snack = 0; p_scl = 1; p_sda = 1; sl_low = 0;
            n_start = 0; n_stop = 0; n_reads = 0; n_mack = 0; n_mnack = 0;
            nack_addr = -1; wcnt = 0; hold_cnt = 0; tb_hold = 0;
            for (int i = 0; i < 8; i++) rxlog[i] = 8'h00;
            for (int i = 0; i < 16; i++) per[i] = 0;
        end else begin
            if (hold_cnt > 0) begin
                hold_cnt = hold_cnt - 1;
                if (hold_cnt == 0) tb_hold = 0;
            end
            if (scl && p_scl && p_sda && !sda) begin
                n_start++; mode = 1; sbit = 0; acking = 0; sl_low = 0;
            end else if (scl && p_scl && !p_sda && sda) begin
                n_stop++; mode = 0; sl_low = 0;
            end else if (scl && !p_scl) begin
                if (mode == 1 && !acking && sbit < 8) begin
                    ssh = {ssh[6:0], sda}; sbit++;
                end else if (mode == 2) begin
                    if (tbit == 5 && sl_addr < 16) per[sl_addr] = cyc - last_rise;
                    if (tbit == 9) begin
                        n_reads++;
                        if (!sda) begin
                            n_mack++; sl_addr++; tbit = 0;
                        end else begin
                            n_mnack++; nack_addr = sl_addr; mode = 0;
                        end
                    end
                end
                last_rise = cyc;
            end else if (!scl && p_scl) begin
                if (mode == 1) begin
                    if (sbit == 8 && !acking) begin
                        acking = 1;
                        if (wcnt < 8) rxlog[wcnt] = ssh;
                        snack = (wcnt == nack_at);
                        sl_low = !snack;
                    end else if (acking) begin
                        acking = 0; sl_low = 0; sbit = 0;
                        if (snack) mode = 0;
                        else if (wcnt == 1) ahi = ssh;
                        else if (wcnt == 2) sl_addr = ahi * 256 + ssh;
                        if (!snack && ssh[0] && (wcnt == 0 || wcnt == 3)) begin
                            mode = 2;
                            sl_low = (sl_addr < 16) ? !img[sl_addr][7] : 1'b1;
                            tbit = 1;
                        end
                        wcnt++;
                    end
                end else if (mode == 2) begin
                    if (sl_addr == hold_byte && tbit == 4 && hold_len > 0) begin
                        tb_hold = 1; hold_cnt = hold_len;
                    end
                    if (tbit < 8) begin
                        sl_low = (sl_addr < 16) ? !img[sl_addr][7 - tbit] : 1'b1;
                        tbit++;
                    end else if (tbit == 8) begin
                        sl_low = 0; tbit = 9;
                    end
                end
            end
            p_scl = scl; p_sda = sda;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bit-serial reference: MSB first, feedback into polynomial 0x07
    function automatic logic [7:0] ref_crc(input int n);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = r[7] ^ img[i][b];
                r = {r[6:0], 1'b0};
                if (fb) r = r ^ 8'h07;
            end
        end
        return r;
    endfunction

    task automatic hread(input int a, output logic ack, output logic [7:0] dat);
        @(negedge clk);
        host_rd = 1'b1;
        host_addr = a[AW-1:0];
        @(negedge clk);
        host_rd = 1'b0;
        ack = host_ack;
        dat = host_rdata;
    endtask

    task automatic load(input int seed, input bit fast_bit, input bit bad_crc);
        for (int i = 0; i < LAST; i++) img[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
        img[1][7] = fast_bit;
        img[LAST] = ref_crc(LAST) ^ (bad_crc ? 8'h01 : 8'h00);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 20000 && !done; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic sweep(input string req, input bit good);
        logic a;
        logic [7:0] dv;
        for (int i = 0; i <= LAST; i++) begin
            hread(i, a, dv);
            chk("R7", "host_ack after finish", int'(a), 1);
            chk(req, $sformatf("host data at %0d", i), int'(dv),
                (good && i < LAST) ? int'(img[i]) : 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] dv;

        // reset state
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy), 1);
        chk("R9", "lines released in reset", int'(scl_oe || sda_oe), 0);
        chk("R4", "done/err in reset", int'(done || err), 0);

        // A: fast bit set, good CRC, short clock stretch on byte 3
        hold_len = 20; hold_byte = 3; nack_at = -1;
        load(1, 1'b1, 1'b0);
        hread(0, a, dv);
        chk("R7", "host_ack while busy", int'(a), 0);
        wait_end();
        chk("R1", "device write byte", int'(rxlog[0]), 8'hA0);
        chk("R1", "address high byte", int'(rxlog[1]), 8'h00);
        chk("R1", "address low byte", int'(rxlog[2]), 8'h00);
        chk("R1", "device read byte", int'(rxlog[3]), 8'hA1);
        chk("R1", "start count", n_start, 2);
        chk("R2", "bytes read", n_reads, LAST + 1);
        chk("R2", "bytes acknowledged", n_mack, LAST);
        chk("R2", "unacknowledged byte address", nack_addr, LAST);
        chk("R2", "stop issued", n_stop, 1);
        chk("R3", "slow period byte 0", per[0], 4 * SQ + 2);
        chk("R3", "slow period byte 1", per[1], 4 * SQ + 2);
        chk("R3", "fast period byte 2", per[2], 4 * FQ + 2);
        chk("R3", "fast period last byte", per[LAST], 4 * FQ + 2);
        chk("R6", "short stretch tolerated err", int'(err), 0);
        chk("R4", "good CRC done", int'(done), 1);
        chk("R9", "lines released after done", int'(scl_oe || sda_oe), 0);
        sweep("R8", 1'b1);

        // B: fast bit clear, corrupted CRC byte
        hold_len = 0; hold_byte = -1;
        load(2, 1'b0, 1'b1);
        wait_end();
        chk("R3", "slow period byte 2", per[2], 4 * SQ + 2);
        chk("R3", "slow period last byte", per[LAST], 4 * SQ + 2);
        chk("R2", "bytes read before CRC check", n_reads, LAST + 1);
        chk("R4", "bad CRC err", int'(err), 1);
        chk("R4", "bad CRC done", int'(done), 1);
        sweep("R8", 1'b0);

        // C: device refuses its address
        nack_at = 0;
        load(3, 1'b1, 1'b0);
        wait_end();
        chk("R5", "no data after refused address", n_reads, 0);
        chk("R5", "stop after refusal", n_stop, 1);
        chk("R5", "err after refusal", int'(err), 1);
        chk("R9", "lines released after refusal", int'(scl_oe || sda_oe), 0);
        sweep("R8", 1'b0);

        // D: device refuses low word address byte
        nack_at = 2;
        load(4, 1'b0, 1'b0);
        wait_end();
        chk("R5", "single start with refused word address", n_start, 1);
        chk("R5", "no data after refused word address", n_reads, 0);
        chk("R5", "err after refused word address", int'(err), 1);

        // E: clock held low beyond the limit during byte 4
        nack_at = -1; hold_len = 300; hold_byte = 4;
        load(5, 1'b1, 1'b0);
        wait_end();
        chk("R6", "timeout err", int'(err), 1);
        chk("R6", "timeout done", int'(done), 1);
        chk("R6", "bus released after timeout", int'(scl_oe || sda_oe), 0);
        chk("R6", "read cut short", int'(n_reads < LAST), 1);
        repeat (320) @(negedge clk);
        sweep("R8", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule